// File: doc/BRIEF.md
# Accumulator Machine Instruction Decoder

This block turns one 8-bit instruction word of a small accumulator machine into the control and address signals for a single transfer. The instruction has three fields: an operation, a destination register and a combined source/addressing field. The decoder selects the data source (A, the immediate D, the input port or RAM). It forms a 16-bit memory address from X, Y and D, and raises the write enables for RAM and for the A, X, Y and OUT registers. It also supplies the ALU operation code, flags branches and strobes an X post-increment.

The 3-bit source/addressing field does not mean the same thing in every instruction class. Loads and ALU operations, stores and branches each read it in their own way. A destination of OUT changes some of the addressing modes, and adds the auto-incrementing [Y:X++] mode. The block holds the X index register, so the post-increment and plain loads of X can be seen at a port. A, Y, the ALU, the memory and the branch condition belong to the surrounding datapath.

Top module: `acc_decoder`

## Requirements
- R1: The instruction has the operation in bits 7:5, the destination in bits 4:3 and the mode in bits 2:0. Operations 0..7 are LD, ADD, SUB, AND, OR, XOR, store, branch. Destinations 0..3 are A, X, Y, OUT. The ALU code output gives operations 0..5 unchanged and gives 6 (pass source) for stores and branches.
- R2: The low address byte is X for even mode values and D for odd mode values.
- R3: The high address byte is 0 for modes 0..3 and for every branch. It is Y for modes 4, 5 and 6. For mode 7 it is X, except that a destination of OUT selects Y.
- R4: The source select is coded 0=A, 1=D, 2=IN, 3=RAM. For LD and ALU operations, mode 2 selects D, mode 3 selects A and every other mode selects RAM, so IN is never selected.
- R5: A store takes its source from the mode: A for modes 0, 3, 4 and 7, IN for modes 1 and 5, D for modes 2 and 6. RAM write is asserted for every store and for nothing else.
- R6: A store never writes A or OUT. A store to destination X or Y writes that register.
- R7: An LD or ALU operation writes exactly the register its destination field names.
- R8: A branch raises the branch flag and writes no register. It selects RAM for modes 0, 1, 4 and 5, D for modes 2 and 6, and A for modes 3 and 7.
- R9: The X-increment strobe is high for a non-branch instruction whose destination is OUT and whose mode is 4 or 6, and low otherwise.
- R10: X resets to 0. On a clock edge it becomes X+1 modulo 256 when the strobe is high, or else takes the bus value when X is written, or else holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of X |
| instr_i | input | 8 | Instruction word |
| bus_i | input | 8 | Value loaded into X when X is written |
| y_i | input | 8 | Current Y register |
| d_i | input | 8 | Immediate byte of the instruction |
| src_sel_o | output | 2 | Data source: 0 A, 1 D, 2 IN, 3 RAM |
| addr_o | output | 16 | Memory address, high byte in bits 15:8 |
| ram_we_o | output | 1 | RAM write enable |
| we_a_o | output | 1 | A write enable |
| we_x_o | output | 1 | X write enable |
| we_y_o | output | 1 | Y write enable |
| we_out_o | output | 1 | OUT write enable |
| alu_op_o | output | 3 | ALU operation, 6 = pass source |
| branch_o | output | 1 | Branch instruction flag |
| x_inc_o | output | 1 | X post-increment strobe |
| x_o | output | 8 | Current X register |

## Verification
Every one of the 256 instruction words is applied with X, Y and D holding distinct, changing bytes. A swap between X and Y, or between X and D, in either address byte therefore shows up as a wrong value. A hand-built table at fixed X, Y and D covers one instruction from each class, including mode 7 with and without the OUT destination, and separates the [X:D] and [Y:D] forms. Directed runs load X with 0xFF and then issue the two [Y:X++] forms to show the wrap to 0 and the step to 1. An increment instruction held during reset shows that reset has priority.

// File: rtl/accdec_pkg.sv
package accdec_pkg;

    localparam int unsigned INSTR_W  = 8;
    localparam int unsigned OP_W     = 3;
    localparam int unsigned DST_W    = 2;
    localparam int unsigned MODE_W   = 3;
    localparam int unsigned MODE_LSB = 0;
    localparam int unsigned DST_LSB  = MODE_LSB + MODE_W;
    localparam int unsigned OP_LSB   = DST_LSB + DST_W;
    localparam int unsigned NUM_DST  = 1 << DST_W;

    typedef enum logic [OP_W-1:0] {
        OP_LD  = 3'd0,
        OP_ADD = 3'd1,
        OP_SUB = 3'd2,
        OP_AND = 3'd3,
        OP_OR  = 3'd4,
        OP_XOR = 3'd5,
        OP_ST  = 3'd6,
        OP_BR  = 3'd7
    } op_e;

    typedef enum logic [DST_W-1:0] {
        DST_A   = 2'd0,
        DST_X   = 2'd1,
        DST_Y   = 2'd2,
        DST_OUT = 2'd3
    } dst_e;

    typedef enum logic [1:0] {
        SRC_A   = 2'd0,
        SRC_D   = 2'd1,
        SRC_IN  = 2'd2,
        SRC_RAM = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        ALU_LD   = 3'd0,
        ALU_ADD  = 3'd1,
        ALU_SUB  = 3'd2,
        ALU_AND  = 3'd3,
        ALU_OR   = 3'd4,
        ALU_XOR  = 3'd5,
        ALU_PASS = 3'd6
    } alu_e;

    typedef enum logic [1:0] {
        HI_ZERO = 2'd0,
        HI_Y    = 2'd1,
        HI_X    = 2'd2
    } hi_sel_e;

    typedef struct packed {
        src_e src;
        logic ram_we;
        logic we_a;
        logic we_x;
        logic we_y;
        logic we_out;
        alu_e alu;
        logic branch;
        logic x_inc;
    } ctrl_t;

endpackage

// File: rtl/accdec_ctrl.sv
module accdec_ctrl
    import accdec_pkg::*;
(
    input  op_e                op_i,
    input  dst_e               dst_i,
    input  logic [MODE_W-1:0]  mode_i,
    output ctrl_t              ctrl_o
);

    src_e               reg_src;
    logic               inc_mode;
    logic [NUM_DST-1:0] dst_hot;
    logic               is_st;
    logic               is_br;

    assign is_st    = (op_i == OP_ST);
    assign is_br    = (op_i == OP_BR);
    assign inc_mode = mode_i[2] & ~mode_i[0];

    // one-hot destination decode, one bit per destination register
    for (genvar g = 0; g < NUM_DST; g++) begin : g_dst
        assign dst_hot[g] = (dst_i == dst_e'(g));
    end

    // register source picked by the two low mode bits
    always_comb begin
        unique case (mode_i[1:0])
            2'd0:    reg_src = SRC_A;
            2'd1:    reg_src = SRC_IN;
            2'd2:    reg_src = SRC_D;
            default: reg_src = SRC_A;
        endcase
    end

    always_comb begin
        ctrl_o      = '0;
        ctrl_o.src  = SRC_RAM;
        ctrl_o.alu  = ALU_PASS;
        if (is_st) begin
            ctrl_o.src    = reg_src;
            ctrl_o.ram_we = 1'b1;
            ctrl_o.we_x   = dst_hot[DST_X];
            ctrl_o.we_y   = dst_hot[DST_Y];
            ctrl_o.x_inc  = dst_hot[DST_OUT] & inc_mode;
        end else if (is_br) begin
            ctrl_o.branch = 1'b1;
            ctrl_o.src    = mode_i[1] ? reg_src : SRC_RAM;
        end else begin
            ctrl_o.alu    = alu_e'(op_i);
            if (mode_i == 3'd2)      ctrl_o.src = SRC_D;
            else if (mode_i == 3'd3) ctrl_o.src = SRC_A;
            else                     ctrl_o.src = SRC_RAM;
            ctrl_o.we_a   = dst_hot[DST_A];
            ctrl_o.we_x   = dst_hot[DST_X];
            ctrl_o.we_y   = dst_hot[DST_Y];
            ctrl_o.we_out = dst_hot[DST_OUT];
            ctrl_o.x_inc  = dst_hot[DST_OUT] & inc_mode;
        end
    end

endmodule

// File: rtl/accdec_addr.sv
module accdec_addr
    import accdec_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic [MODE_W-1:0] mode_i,
    input  logic              branch_i,
    input  logic              dst_out_i,
    input  logic [DW-1:0]     x_i,
    input  logic [DW-1:0]     y_i,
    input  logic [DW-1:0]     d_i,
    output logic [DW-1:0]     hi_o,
    output logic [DW-1:0]     lo_o
);

    hi_sel_e hi_sel;

    always_comb begin
        if (branch_i || !mode_i[2])
            hi_sel = HI_ZERO;
        else if ((mode_i == 3'd7) && !dst_out_i)
            hi_sel = HI_X;
        else
            hi_sel = HI_Y;
    end

    always_comb begin
        unique case (hi_sel)
            HI_Y:    hi_o = y_i;
            HI_X:    hi_o = x_i;
            default: hi_o = '0;
        endcase
    end

    assign lo_o = mode_i[0] ? d_i : x_i;

endmodule

// File: rtl/accdec_xreg.sv
module accdec_xreg #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          load_i,
    input  logic [DW-1:0] load_val_i,
    output logic [DW-1:0] x_o
);

    typedef struct packed {
        logic [DW-1:0] x;
    } xst_t;

    xst_t st_d;
    xst_t st_q;

    always_comb begin
        st_d = st_q;
        if (inc_i)
            st_d.x = st_q.x + 1'b1;
        else if (load_i)
            st_d.x = load_val_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign x_o = st_q.x;

    AST_X_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |=> (st_q.x == DW'($past(st_q.x) + 1'b1)));           // R10
    AST_X_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !inc_i) |=> (st_q.x == $past(load_val_i)));       // R10
    AST_X_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !inc_i) |=> $stable(st_q.x));                    // R10

endmodule

// File: rtl/acc_decoder.sv
module acc_decoder
    import accdec_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [DW-1:0]     bus_i,
    input  logic [DW-1:0]     y_i,
    input  logic [DW-1:0]     d_i,
    output logic [1:0]        src_sel_o,
    output logic [2*DW-1:0]   addr_o,
    output logic              ram_we_o,
    output logic              we_a_o,
    output logic              we_x_o,
    output logic              we_y_o,
    output logic              we_out_o,
    output logic [2:0]        alu_op_o,
    output logic              branch_o,
    output logic              x_inc_o,
    output logic [DW-1:0]     x_o
);

    op_e               op;
    dst_e              dst;
    logic [MODE_W-1:0] mode;
    ctrl_t             ctrl;
    logic [DW-1:0]     x_q;
    logic [DW-1:0]     addr_hi;
    logic [DW-1:0]     addr_lo;

    assign op   = op_e'(instr_i[OP_LSB +: OP_W]);
    assign dst  = dst_e'(instr_i[DST_LSB +: DST_W]);
    assign mode = instr_i[MODE_LSB +: MODE_W];

    accdec_ctrl u_ctrl (
        .op_i   (op),
        .dst_i  (dst),
        .mode_i (mode),
        .ctrl_o (ctrl)
    );

    accdec_addr #(.DW(DW)) u_addr (
        .mode_i    (mode),
        .branch_i  (ctrl.branch),
        .dst_out_i (dst == DST_OUT),
        .x_i       (x_q),
        .y_i       (y_i),
        .d_i       (d_i),
        .hi_o      (addr_hi),
        .lo_o      (addr_lo)
    );

    accdec_xreg #(.DW(DW)) u_xreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_i      (ctrl.x_inc),
        .load_i     (ctrl.we_x),
        .load_val_i (bus_i),
        .x_o        (x_q)
    );

    assign src_sel_o = ctrl.src;
    assign addr_o    = {addr_hi, addr_lo};
    assign ram_we_o  = ctrl.ram_we;
    assign we_a_o    = ctrl.we_a;
    assign we_x_o    = ctrl.we_x;
    assign we_y_o    = ctrl.we_y;
    assign we_out_o  = ctrl.we_out;
    assign alu_op_o  = ctrl.alu;
    assign branch_o  = ctrl.branch;
    assign x_inc_o   = ctrl.x_inc;
    assign x_o       = x_q;

    AST_BR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        branch_o |-> !(we_a_o || we_x_o || we_y_o || we_out_o));     // R8
    AST_BR_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        branch_o |-> (addr_o[2*DW-1:DW] == '0));                     // R3
    AST_ST_NO_REG: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> !(we_a_o || we_out_o));                         // R6
    AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({we_a_o, we_x_o, we_y_o, we_out_o}) <= 1);        // R7
    AST_NO_IN_ALU: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_we_o && !branch_o) |-> (src_sel_o != SRC_IN));         // R4
    AST_INC_NOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !(x_inc_o && we_x_o));                                       // R9

endmodule

// File: tb/sim_acc_decoder.sv
module sim_acc_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int NTBL = 8;

    // {instr, req number, src, addr, ram_we, we_a/x/y/out, alu, branch, x_inc}
    localparam logic [39:0] TBL [NTBL] = '{
        {8'h07, 4'd3, 2'd3, 16'h3C34, 1'b0, 4'b1000, 3'd0, 1'b0, 1'b0},
        {8'hDF, 4'd3, 2'd0, 16'h1234, 1'b1, 4'b0000, 3'd6, 1'b0, 1'b0},
        {8'hF5, 4'd8, 2'd3, 16'h0034, 1'b0, 4'b0000, 3'd6, 1'b1, 1'b0},
        {8'h32, 4'd4, 2'd1, 16'h003C, 1'b0, 4'b0010, 3'd1, 1'b0, 1'b0},
        {8'hBB, 4'd7, 2'd0, 16'h0034, 1'b0, 4'b0001, 3'd5, 1'b0, 1'b0},
        {8'hD1, 4'd5, 2'd2, 16'h0034, 1'b1, 4'b0010, 3'd6, 1'b0, 1'b0},
        {8'h46, 4'd2, 2'd3, 16'h123C, 1'b0, 4'b1000, 3'd2, 1'b0, 1'b0},
        {8'hFF, 4'd8, 2'd0, 16'h0034, 1'b0, 4'b0000, 3'd6, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  instr = 8'h00;
    logic [7:0]  bus = 8'h00;
    logic [7:0]  y = 8'h00;
    logic [7:0]  d = 8'h00;
    logic [1:0]  src_sel;
    logic [15:0] addr;
    logic        ram_we, we_a, we_x, we_y, we_out, branch, x_inc;
    logic [2:0]  alu_op;
    logic [7:0]  x;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    logic [7:0] xm = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_decoder u0 (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .bus_i(bus), .y_i(y), .d_i(d),
        .src_sel_o(src_sel), .addr_o(addr), .ram_we_o(ram_we), .we_a_o(we_a),
        .we_x_o(we_x), .we_y_o(we_y), .we_out_o(we_out), .alu_op_o(alu_op),
        .branch_o(branch), .x_inc_o(x_inc), .x_o(x)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected outputs built from the requirements
    function automatic logic [27:0] ref_out(input logic [7:0] ins, input logic [7:0] xv,
                                            input logic [7:0] yv, input logic [7:0] dv);
        logic [2:0] op = ins[7:5];
        logic [1:0] dst = ins[4:3];
        logic [2:0] m = ins[2:0];
        logic st = (op == 3'd6);
        logic br = (op == 3'd7);
        logic [1:0] rs, src;
        logic [7:0] hi, lo;
        case (m[1:0])
            2'd0: rs = 2'd0;
            2'd1: rs = 2'd2;
            2'd2: rs = 2'd1;
            default: rs = 2'd0;
        endcase
        if (st)           src = rs;
        else if (br)      src = m[1] ? rs : 2'd3;
        else if (m == 2)  src = 2'd1;
        else if (m == 3)  src = 2'd0;
        else              src = 2'd3;
        if (br || m < 4)                hi = 8'h00;
        else if (m == 7 && dst != 2'd3) hi = xv;
        else                            hi = yv;
        lo = m[0] ? dv : xv;
        return {src, hi, lo, st,
                (!st && !br && dst == 0), (!br && dst == 1), (!br && dst == 2),
                (!st && !br && dst == 3),
                (st || br) ? 3'd6 : op, br,
                (!br && dst == 3 && (m == 4 || m == 6))};
    endfunction

    task automatic step(input logic [7:0] ins, input logic [7:0] b,
                        input logic [7:0] yv, input logic [7:0] dv);
        logic [27:0] e;
        string t_src, t_we;
        @(negedge clk);
        instr = ins; bus = b; y = yv; d = dv;
        #1;
        e = ref_out(ins, xm, yv, dv);
        t_src = (ins[7:5] == 6) ? "R5" : (ins[7:5] == 7) ? "R8" : "R4";
        t_we  = (ins[7:5] == 6) ? "R6" : (ins[7:5] == 7) ? "R8" : "R7";
        chk(t_src,  32'(src_sel), 32'(e[27:26]));
        chk("R3",   32'(addr[15:8]), 32'(e[25:18]));
        chk("R2",   32'(addr[7:0]), 32'(e[17:10]));
        chk("R5",   32'(ram_we), 32'(e[9]));
        chk(t_we,   32'({we_a, we_x, we_y, we_out}), 32'(e[8:5]));
        chk("R1",   32'(alu_op), 32'(e[4:2]));
        chk("R8",   32'(branch), 32'(e[1]));
        chk("R9",   32'(x_inc), 32'(e[0]));
        @(posedge clk);
        #1;
        if (e[0])      xm = xm + 8'd1;
        else if (e[7]) xm = b;
        chk("R10", 32'(x), 32'(xm));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // reset held with an increment instruction applied: R10
        instr = 8'hDC; bus = 8'h55;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset", 32'(x), 32'h00);
        rst_n = 1'b1;

        // table at X=3C, Y=12, D=34
        step(8'h0B, 8'h3C, 8'h12, 8'h34);
        for (int i = 0; i < NTBL; i++) begin
            @(negedge clk);
            instr = TBL[i][39:32]; bus = 8'hAA; y = 8'h12; d = 8'h34;
            #1;
            chk($sformatf("R%0d table %0d", TBL[i][31:28], i),
                32'({src_sel, addr, ram_we, we_a, we_x, we_y, we_out, alu_op, branch, x_inc}),
                32'(TBL[i][27:0]));
        end
        @(negedge clk);
        chk("R10 hold", 32'(x), 32'h3C);

        // wrap of X through the two OUT increment forms: R9, R10
        step(8'h0B, 8'hFF, 8'h40, 8'h01);
        step(8'hDC, 8'h77, 8'h40, 8'h01);
        chk("R10 wrap", 32'(x), 32'h00);
        step(8'h1E, 8'h77, 8'h40, 8'h01);
        chk("R9 step", 32'(x), 32'h01);

        // sweep of every instruction word
        for (int i = 0; i < 256; i++)
            step(8'(i), 8'(i * 13 + 5), 8'(i * 7 + 3), ~8'(i));

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule